// File: doc/BRIEF.md
# Panel Sync and Enable Generator

This block drives the timing pins of a parallel RGB panel. It produces horizontal sync, vertical sync, a data-enable window and a one-cycle pixel strobe. The timing is set through a small register port. A frame is laid out as sync pulse, back porch, active region and front porch. Pixels make up the horizontal axis and lines make up the vertical axis. Every length is programmed as its count minus one. A programmable divider sets the pixel rate. It can be bypassed so that one pixel passes on every system clock.

Software writes a shadow copy of the configuration. The running copy takes the shadow contents at the moment a new frame's vertical sync begins. A frame therefore never mixes old and new settings. A guard bit holds the running copy frozen while software rewrites several fields, and the staged set lands at the first frame boundary after the guard drops. While video is off, the shadow copy passes straight through. A frame interrupt with a write-one-to-clear pending bit marks each frame boundary.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, hsync_o, vsync_o, de_o, pclk_en_o and irq_o are all 0, and every register reads 0.
- R2: Register addresses: 0..3 hold horizontal sync, back porch, active and front porch. 4..7 hold the same four fields for the vertical axis. Each of these is a 10-bit count minus one in bits [9:0]; upper write bits are dropped. Address 8 is control: bit0 video on, bit1 divider select, bit2 hsync invert, bit3 vsync invert, bits[15:8] divide ratio minus one. Address 9 bit0 is the guard. Address 10 bit0 is the interrupt enable. Address 11 bit0 is the pending flag. Reads are combinational from rd_addr and return the written (shadow) values. Unused bits and addresses read 0.
- R3: While running, a line lasts (hs+1)+(hbp+1)+(hact+1)+(hfp+1) pixel strobes. The horizontal sync is active for the first hs+1 of them.
- R4: A frame lasts the same sum of the vertical fields, counted in lines. The vertical sync is active during the first vs+1 lines. The line count advances when a line ends.
- R5: de_o is high only when the pixel position lies in the horizontal active region and the line lies in the vertical active region.
- R6: Each sync output is XORed with its own invert bit, including while video is off.
- R7: With the divider select bit clear, pclk_en_o is high on every cycle while running. With it set, pclk_en_o is high once every ratio+1 cycles, and positions advance only on those cycles.
- R8: While running, written values take effect only at the frame boundary, where vsync starts. While video is off, they take effect on the cycle after the write.
- R9: While the guard bit is 1, the running configuration does not change. Staged values are applied at the first frame boundary after the guard returns to 0.
- R10: If the interrupt is enabled when a frame boundary occurs, the pending flag sets and irq_o follows it. Writing 1 to address 11 bit0 clears the flag. Writing 0 leaves it set.
- R11: With video off, both syncs sit at their inactive level (the invert bit), and de_o and pclk_en_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data for rd_addr |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data-enable window |
| pclk_en_o | output | 1 | Pixel strobe |
| irq_o | output | 1 | Frame interrupt (pending flag) |

## Verification
A wrong pixel or line position shows up at hsync_o or de_o within one line. It shows up at vsync_o within one frame, because every output is decoded directly from the two position counters. A commit taken at the wrong moment changes the length of the line or frame in progress, so it shows within that frame rather than the next. A divider fault shows within ratio+1 cycles as a misplaced pixel strobe. The bench runs a cycle model against every output on every cycle, so any of these is caught on the first cycle that differs.

// File: rtl/lcd_sync_pkg.sv
`timescale 1ns/1ps
package lcd_sync_pkg;
   localparam int unsigned ADDR_W   = 4;
   localparam int unsigned N_TIMING = 8;

   typedef enum logic [ADDR_W-1:0] {
      A_HSYNC  = 4'd0,
      A_HBACK  = 4'd1,
      A_HACT   = 4'd2,
      A_HFRONT = 4'd3,
      A_VSYNC  = 4'd4,
      A_VBACK  = 4'd5,
      A_VACT   = 4'd6,
      A_VFRONT = 4'd7,
      A_CTRL   = 4'd8,
      A_GUARD  = 4'd9,
      A_IRQEN  = 4'd10,
      A_IRQST  = 4'd11
   } reg_addr_e;

   localparam int CTL_EN        = 0;
   localparam int CTL_DIV       = 1;
   localparam int CTL_HINV      = 2;
   localparam int CTL_VINV      = 3;
   localparam int CTL_RATIO_LSB = 8;
endpackage

// File: rtl/lcd_pixel_div.sv
`timescale 1ns/1ps
module lcd_pixel_div #(
   parameter int unsigned DIVW    = 8,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            divide,
   input  logic [DIVW-1:0] ratio_m1,
   output logic            tick
);
   generate
      if (HAS_DIV) begin : g_div
         logic [DIVW-1:0] cnt_q;
         logic            hit;
         assign hit  = (cnt_q >= ratio_m1);
         assign tick = !divide || hit;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (!divide || hit)  cnt_q <= '0;
            else                      cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_nodiv
         logic unused_cfg;
         assign unused_cfg = divide ^ (^ratio_m1);
         assign tick = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lcd_axis_timer.sv
`timescale 1ns/1ps
module lcd_axis_timer #(
   parameter int unsigned FW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   input  logic [FW-1:0] sync_m1,
   input  logic [FW-1:0] back_m1,
   input  logic [FW-1:0] act_m1,
   input  logic [FW-1:0] front_m1,
   output logic          in_sync,
   output logic          in_act,
   output logic          at_end
);
   localparam int unsigned CW = FW + 2;

   logic [CW-1:0] pos_q, act_first, act_last, end_idx;

   assign act_first = CW'(sync_m1) + CW'(back_m1) + CW'(2);
   assign act_last  = act_first + CW'(act_m1);
   assign end_idx   = act_last + CW'(front_m1) + CW'(1);

   assign at_end  = (pos_q >= end_idx);
   assign in_sync = (pos_q <= CW'(sync_m1));
   assign in_act  = (pos_q >= act_first) && (pos_q <= act_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pos_q <= '0;
      else if (!run)   pos_q <= '0;
      else if (step)   pos_q <= at_end ? '0 : pos_q + 1'b1;
   end

   // R3
   pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (pos_q <= end_idx));
endmodule

// File: rtl/lcd_cfg_bank.sv
`timescale 1ns/1ps
module lcd_cfg_bank
   import lcd_sync_pkg::*;
#(
   parameter int unsigned FW   = 10,
   parameter int unsigned DIVW = 8,
   parameter int unsigned DW   = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DW-1:0]                  wr_data,
   input  logic [ADDR_W-1:0]              rd_addr,
   output logic [DW-1:0]                  rd_data,
   input  logic                           frame_start,
   output logic [N_TIMING-1:0][FW-1:0]    tim_o,
   output logic                           en_o,
   output logic                           div_o,
   output logic                           hinv_o,
   output logic                           vinv_o,
   output logic [DIVW-1:0]                ratio_o,
   output logic                           irq_o
);
   typedef struct packed {
      logic [DIVW-1:0] ratio;
      logic            vinv;
      logic            hinv;
      logic            div;
      logic            en;
   } ctl_t;

   logic [N_TIMING-1:0][FW-1:0] sh_tim, act_tim;
   ctl_t sh_ctl, act_ctl;
   logic guard_q, ien_q, pend_q;
   logic commit, clr;

   assign commit = !guard_q && (frame_start || !act_ctl.en);
   assign clr    = wr_en && (wr_addr == A_IRQST) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_tim  <= '0;
         sh_ctl  <= '0;
         guard_q <= 1'b0;
         ien_q   <= 1'b0;
      end else if (wr_en) begin
         for (int i = 0; i < N_TIMING; i++)
            if (wr_addr == ADDR_W'(i)) sh_tim[i] <= wr_data[FW-1:0];
         if (wr_addr == A_CTRL) begin
            sh_ctl.en    <= wr_data[CTL_EN];
            sh_ctl.div   <= wr_data[CTL_DIV];
            sh_ctl.hinv  <= wr_data[CTL_HINV];
            sh_ctl.vinv  <= wr_data[CTL_VINV];
            sh_ctl.ratio <= wr_data[CTL_RATIO_LSB +: DIVW];
         end
         if (wr_addr == A_GUARD) guard_q <= wr_data[0];
         if (wr_addr == A_IRQEN) ien_q   <= wr_data[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_tim <= '0;
         act_ctl <= '0;
      end else if (commit) begin
         act_tim <= sh_tim;
         act_ctl <= sh_ctl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q && !clr) || (frame_start && ien_q);
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_TIMING; i++)
         if (rd_addr == ADDR_W'(i)) rd_data[FW-1:0] = sh_tim[i];
      if (rd_addr == A_CTRL) begin
         rd_data[CTL_EN]                  = sh_ctl.en;
         rd_data[CTL_DIV]                 = sh_ctl.div;
         rd_data[CTL_HINV]                = sh_ctl.hinv;
         rd_data[CTL_VINV]                = sh_ctl.vinv;
         rd_data[CTL_RATIO_LSB +: DIVW]   = sh_ctl.ratio;
      end
      if (rd_addr == A_GUARD) rd_data[0] = guard_q;
      if (rd_addr == A_IRQEN) rd_data[0] = ien_q;
      if (rd_addr == A_IRQST) rd_data[0] = pend_q;
   end

   assign tim_o   = act_tim;
   assign en_o    = act_ctl.en;
   assign div_o   = act_ctl.div;
   assign hinv_o  = act_ctl.hinv;
   assign vinv_o  = act_ctl.vinv;
   assign ratio_o = act_ctl.ratio;
   assign irq_o   = pend_q;

   // R9
   guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      guard_q |=> ($stable(act_tim) && $stable(act_ctl)));

   // R8
   commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ctl.en && !frame_start) |=> ($stable(act_tim) && $stable(act_ctl)));

   // R10
   pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(frame_start && ien_q));
endmodule

// File: rtl/lcd_sync_gen.sv
`timescale 1ns/1ps
module lcd_sync_gen
   import lcd_sync_pkg::*;
#(
   parameter int unsigned FW      = 10,
   parameter int unsigned DIVW    = 8,
   parameter int unsigned DW      = 16,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic              pclk_en_o,
   output logic              irq_o
);
   localparam int unsigned N_AXIS    = 2;
   localparam int unsigned PER_AXIS  = N_TIMING / N_AXIS;

   generate
      if (DW < CTL_RATIO_LSB + DIVW || DW < FW || FW < 2) begin : g_bad_width
         $error("lcd_sync_gen: data width too narrow for fields");
      end
   endgenerate

   logic [N_TIMING-1:0][FW-1:0] tim;
   logic              run, div_sel, hinv, vinv, pix_tick, frame_start;
   logic [DIVW-1:0]   ratio_m1;
   logic [N_AXIS-1:0] step, in_sync, in_act, at_end;

   lcd_cfg_bank #(.FW(FW), .DIVW(DIVW), .DW(DW)) i_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .frame_start (frame_start),
      .tim_o       (tim),
      .en_o        (run),
      .div_o       (div_sel),
      .hinv_o      (hinv),
      .vinv_o      (vinv),
      .ratio_o     (ratio_m1),
      .irq_o       (irq_o)
   );

   lcd_pixel_div #(.DIVW(DIVW), .HAS_DIV(HAS_DIV)) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .divide   (div_sel),
      .ratio_m1 (ratio_m1),
      .tick     (pix_tick)
   );

   assign step[0] = pix_tick;
   assign step[1] = pix_tick && at_end[0];

   generate
      for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
         lcd_axis_timer #(.FW(FW)) i_axis (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .step     (step[g]),
            .sync_m1  (tim[g*PER_AXIS + 0]),
            .back_m1  (tim[g*PER_AXIS + 1]),
            .act_m1   (tim[g*PER_AXIS + 2]),
            .front_m1 (tim[g*PER_AXIS + 3]),
            .in_sync  (in_sync[g]),
            .in_act   (in_act[g]),
            .at_end   (at_end[g])
         );
      end
   endgenerate

   assign frame_start = run && pix_tick && at_end[0] && at_end[1];

   assign hsync_o   = (run && in_sync[0]) ^ hinv;
   assign vsync_o   = (run && in_sync[1]) ^ vinv;
   assign de_o      = run && in_act[0] && in_act[1];
   assign pclk_en_o = run && pix_tick;

   // R5
   de_vs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      de_o |-> ((vsync_o == vinv) && (hsync_o == hinv)));

   // R11
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!de_o && !pclk_en_o));

   generate
      if (HAS_DIV) begin : g_div_chk
         // R7
         pclk_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pclk_en_o && div_sel && ratio_m1 != '0) |=>
               (!pclk_en_o || !div_sel || ratio_m1 == '0));
      end
   endgenerate
endmodule

// File: tb/test_lcd_sync_gen.sv
`timescale 1ns/1ps
module test_lcd_sync_gen;
   localparam int FW = 10, DIVW = 8, DW = 16;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [3:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic hsync_o, vsync_o, de_o, pclk_en_o, irq_o;

   always #2.5 clk = ~clk;

   lcd_sync_gen #(.FW(FW), .DIVW(DIVW), .DW(DW)) i_lcd_sync_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
      .pclk_en_o(pclk_en_o), .irq_o(irq_o));

   typedef struct {
      bit hs; bit vs; bit de; bit pe; bit irq;
      logic [DW-1:0] rd;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   string phase = "R1";
   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   // reference model state
   int m_sh[8], m_at[8];
   bit ms_en, ms_div, ms_hi, ms_vi, ma_en, ma_div, ma_hi, ma_vi;
   int ms_ratio, ma_ratio, m_dcnt, m_h, m_v;
   bit m_guard, m_ien, m_pend;

   function automatic int model_rd(int a);
      if (a < 8)  return m_sh[a];
      if (a == 8) return (ms_ratio << 8) | (ms_vi << 3) | (ms_hi << 2) | (ms_div << 1) | ms_en;
      if (a == 9) return m_guard;
      if (a == 10) return m_ien;
      if (a == 11) return m_pend;
      return 0;
   endfunction

   always @(negedge clk) begin : model
      int hend, vend, nd;
      bit pe, hl, vl, fs, cm, clr;
      exp_t e;
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin m_sh[i] = 0; m_at[i] = 0; end
         {ms_en, ms_div, ms_hi, ms_vi, ma_en, ma_div, ma_hi, ma_vi} = '0;
         ms_ratio = 0; ma_ratio = 0; m_dcnt = 0; m_h = 0; m_v = 0;
         m_guard = 0; m_ien = 0; m_pend = 0;
      end else begin
         hend = m_at[0] + m_at[1] + m_at[2] + m_at[3] + 3;
         vend = m_at[4] + m_at[5] + m_at[6] + m_at[7] + 3;
         pe   = !ma_div || (m_dcnt >= ma_ratio);
         hl   = m_h >= hend;
         vl   = m_v >= vend;
         fs   = ma_en && pe && hl && vl;
         cm   = !m_guard && (fs || !ma_en);
         clr  = wr_en && wr_addr == 4'd11 && wr_data[0];
         nd   = pe ? 0 : m_dcnt + 1;
         if (!ma_div) nd = 0;
         if (!ma_en) begin m_h = 0; m_v = 0; end
         else if (pe) begin
            if (hl) begin m_h = 0; m_v = vl ? 0 : m_v + 1; end
            else m_h = m_h + 1;
         end
         m_dcnt = nd;
         m_pend = (m_pend && !clr) || (fs && m_ien);
         if (cm) begin
            for (int i = 0; i < 8; i++) m_at[i] = m_sh[i];
            ma_en = ms_en; ma_div = ms_div; ma_hi = ms_hi; ma_vi = ms_vi; ma_ratio = ms_ratio;
         end
         if (wr_en) begin
            if (wr_addr < 4'd8) m_sh[wr_addr] = int'(wr_data[FW-1:0]);
            if (wr_addr == 4'd8) begin
               ms_en = wr_data[0]; ms_div = wr_data[1]; ms_hi = wr_data[2];
               ms_vi = wr_data[3]; ms_ratio = int'(wr_data[15:8]);
            end
            if (wr_addr == 4'd9)  m_guard = wr_data[0];
            if (wr_addr == 4'd10) m_ien   = wr_data[0];
         end
      end
      e.hs  = (ma_en && m_h <= m_at[0]) ^ ma_hi;
      e.vs  = (ma_en && m_v <= m_at[4]) ^ ma_vi;
      e.de  = ma_en && m_h >= m_at[0] + m_at[1] + 2 && m_h <= m_at[0] + m_at[1] + m_at[2] + 2
              && m_v >= m_at[4] + m_at[5] + 2 && m_v <= m_at[4] + m_at[5] + m_at[6] + 2;
      e.pe  = ma_en && (!ma_div || m_dcnt >= ma_ratio);
      e.irq = m_pend;
      e.rd  = DW'(model_rd(int'(rd_addr)));
      e.tag = phase;
      exp_q.push_back(e);
   end

   task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      exp_t e;
      #0.2;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         chk({e.tag, "/R3"},  "hsync",   DW'(hsync_o),   DW'(e.hs));
         chk({e.tag, "/R4"},  "vsync",   DW'(vsync_o),   DW'(e.vs));
         chk({e.tag, "/R5"},  "de",      DW'(de_o),      DW'(e.de));
         chk({e.tag, "/R7"},  "pclk_en", DW'(pclk_en_o), DW'(e.pe));
         chk({e.tag, "/R10"}, "irq",     DW'(irq_o),     DW'(e.irq));
         chk({e.tag, "/R2"},  "rd_data", rd_data,        e.rd);
      end
   end

   task automatic summary();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = DW'(d);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int t0, cnt;
      bit prev;
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      phase = "R1";
      idle(3);
      #1;
      // R1: all outputs low right after reset
      chk("R1", "outputs", DW'({hsync_o, vsync_o, de_o, pclk_en_o, irq_o}), '0);

      phase = "R2";
      wr(0, 1); wr(1, 1); wr(2, 16'hFC07); wr(3, 2);
      wr(4, 0); wr(5, 1); wr(6, 3); wr(7, 0);
      for (int a = 0; a < 13; a++) begin @(negedge clk); #1 rd_addr = 4'(a); end
      @(negedge clk); #1;
      rd_addr = 4'd2;
      @(negedge clk); #1;
      // R2: upper write bits dropped in a timing field
      chk("R2", "hact readback", rd_data, 16'h0007);

      phase = "R6";
      wr(8, 16'h000C);
      idle(4); #1;
      // R6: inverted idle levels while video off
      chk("R6", "idle syncs", DW'({hsync_o, vsync_o}), 16'h0003);

      phase = "R11";
      wr(8, 0);
      idle(4);

      phase = "R3";
      rd_addr = 4'd11;
      wr(10, 1);
      wr(8, 16'h0001);
      idle(2); #1;
      prev = hsync_o; t0 = -1; cnt = 0;
      while (cnt < 2) begin
         @(negedge clk); #1;
         if (hsync_o && !prev) begin
            // R3: line length 2+2+8+3 = 15 cycles
            if (t0 >= 0) chk("R3", "line period", DW'(cyc - t0), 16'd15);
            t0 = cyc; cnt++;
         end
         prev = hsync_o;
      end
      idle(300);

      phase = "R10";
      wr(11, 0);
      idle(3);
      wr(11, 1);
      idle(250);

      phase = "R8";
      wr(2, 4); wr(6, 2);
      idle(300);

      phase = "R9";
      wr(9, 1); wr(2, 9); wr(5, 2);
      idle(300);
      wr(9, 0);
      idle(300);

      phase = "R7";
      wr(8, 16'h0203);
      idle(400);
      cnt = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); #1; cnt += pclk_en_o; end
      // R7: one strobe per 3 cycles
      chk("R7", "strobe count", DW'(cnt), 16'd10);
      idle(400);
      wr(8, 16'h0003);
      idle(300);

      phase = "R6";
      wr(8, 16'h000D);
      idle(300);

      phase = "R11";
      wr(8, 0);
      idle(300);
      idle(2);
      summary();
   end
endmodule